// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 hardware event pulses into a sticky cause vector and gates them with a per-bit mask to produce a single interrupt request. One copy is placed per interrupt source (transmit, receive and miscellaneous), and a small register bus gives software control over all of it. Software can raise causes itself, mask or unmask individual bits through separate set and clear write strobes, and look at either the raw causes, the causes that survive the mask, or the mask itself.

Every cause bit is cleared in one of two ways, chosen per bit by a clear-mode register. A bit in read-clear mode is cleared by the act of reading the cause register. A bit in write-clear mode is cleared only when software writes a 1 to it, so writing back a value just read acknowledges exactly the events that were observed. An incoming event always wins over a clear in the same cycle, so no pulse is lost. Masking never stops a cause from being latched; it only gates the interrupt output.

The bus uses a 3-bit register select: 0 cause, 1 cause-set, 2 mask-set, 3 mask-clear, 4 clear-mode, 5 masked-cause view, 6 mask view; select 7 is unmapped. Write strobes and read strobes are single-cycle; read data appears on the cycle after the read strobe and holds until the next read.

Top module: `icr_bank`

## Requirements
- R1: After reset the cause vector is zero, the mask is all ones, the clear-mode register is zero and the interrupt output is low.
- R2: A 1 on an event input bit sets that cause bit at the next clock edge whether or not the bit is masked, and the bit stays set until cleared.
- R3: Writing to the cause-set register (select 1) sets every cause bit written as 1; bits written as 0 are unchanged.
- R4: Writing to the mask-set register (select 2) sets the written-1 mask bits and writing to the mask-clear register (select 3) clears them; mask bits written as 0 are unchanged in both cases.
- R5: The clear-mode register (select 4) is read/write; bit value 1 puts that cause bit in read-clear mode, 0 in write-clear mode.
- R6: A read of the cause register (select 0) returns the vector as it was before the read and clears every cause bit whose clear-mode bit is 1; bits in write-clear mode are left set.
- R7: A write to the cause register clears each bit written as 1 whose clear-mode bit is 0; bits in read-clear mode ignore the write, and writing back a value read earlier clears exactly those bits and no later ones.
- R8: An event or cause-set on a bit in the same cycle as a read-clear or write-clear of that bit leaves the bit set.
- R9: The masked-cause view (select 5) reads cause AND NOT mask, the mask view (select 6) reads the mask, and neither read changes any state.
- R10: The interrupt output equals the OR of cause AND NOT mask, delayed by one register stage.
- R11: Bit 27 can be masked independently; writing 0xF7FFFFFF to mask-set after unmasking all bits leaves only bit 27 able to raise the interrupt.
- R12: Read data appears the cycle after the read strobe; selects 1, 2, 3 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | NUM_EVT | Hardware event pulses, one per cause bit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | NUM_EVT | Write data |
| bus_rdata_o | output | NUM_EVT | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a clear colliding with a set on the same bit in the same cycle, because an ordinary bus sequence separates the two. The stimulus drives an event pulse in exactly the cycle of a cause read (read-clear bit) and of a cause write (write-clear bit), then reads again to prove the bit survived. A per-bit sweep walks every cause bit through latch-while-masked, write-clear and read-clear, and a separate step raises new events between a read and its write-back to show that only the observed bits are acknowledged.

// File: rtl/icr_pkg.sv
package icr_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CAUSE = 3'd0,
    SEL_CSET  = 3'd1,
    SEL_MSET  = 3'd2,
    SEL_MCLR  = 3'd3,
    SEL_MODE  = 3'd4,
    SEL_MVIEW = 3'd5,
    SEL_MASKV = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/icr_cause_bank.sv
module icr_cause_bank #(
  parameter int unsigned NUM_EVT = 32
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] sw_set_i,
  input  logic [NUM_EVT-1:0] w1c_i,
  input  logic               rd_clr_i,
  input  logic [NUM_EVT-1:0] mode_i,
  output logic [NUM_EVT-1:0] cause_o
);

  for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
    logic set_b;
    logic clr_b;
    logic en_b;
    logic bit_q;

    // set has priority: when set is active the loaded value is 1
    always_comb begin
      set_b = evt_i[b] | sw_set_i[b];
      clr_b = (rd_clr_i & mode_i[b]) | (w1c_i[b] & ~mode_i[b]);
      en_b  = set_b | clr_b;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (en_b) begin
        bit_q <= set_b;
      end
    end

    assign cause_o[b] = bit_q;
  end

endmodule

// File: rtl/icr_mask_mode.sv
module icr_mask_mode #(
  parameter int unsigned NUM_EVT = 32
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic               mset_en_i,
  input  logic               mclr_en_i,
  input  logic               mode_en_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] mask_o,
  output logic [NUM_EVT-1:0] mode_o
);

  logic [NUM_EVT-1:0] mask_q, mask_d;
  logic [NUM_EVT-1:0] mode_q;
  logic               mask_en;

  always_comb begin
    mask_en = mset_en_i | mclr_en_i;
    mask_d  = mask_q;
    if (mset_en_i) begin
      mask_d = mask_q | wdata_i;
    end else if (mclr_en_i) begin
      mask_d = mask_q & ~wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en_i) begin
      mode_q <= wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/icr_read_port.sv
module icr_read_port
  import icr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 32
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic               rd_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] cause_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic [NUM_EVT-1:0] mode_i,
  output logic [NUM_EVT-1:0] rdata_o
);

  logic [NUM_EVT-1:0] rdata_d, rdata_q;

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_CAUSE: rdata_d = cause_i;
      SEL_MODE:  rdata_d = mode_i;
      SEL_MVIEW: rdata_d = cause_i & ~mask_i;
      SEL_MASKV: rdata_d = mask_i;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/icr_bank.sv
module icr_bank
  import icr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 32
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [SEL_W-1:0]   bus_addr_i,
  input  logic [NUM_EVT-1:0] bus_wdata_i,
  output logic [NUM_EVT-1:0] bus_rdata_o,
  output logic               irq_o
);

  logic rst_s1_q;
  logic rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [NUM_EVT-1:0] sw_set;
  logic [NUM_EVT-1:0] w1c;
  logic               rd_clr;
  logic               mset_en, mclr_en, mode_en;

  always_comb begin
    sw_set  = '0;
    w1c     = '0;
    rd_clr  = bus_rd_i && (bus_addr_i == SEL_CAUSE);
    mset_en = bus_wr_i && (bus_addr_i == SEL_MSET);
    mclr_en = bus_wr_i && (bus_addr_i == SEL_MCLR);
    mode_en = bus_wr_i && (bus_addr_i == SEL_MODE);
    if (bus_wr_i && (bus_addr_i == SEL_CSET))  sw_set = bus_wdata_i;
    if (bus_wr_i && (bus_addr_i == SEL_CAUSE)) w1c    = bus_wdata_i;
  end

  logic [NUM_EVT-1:0] cause_q;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] mode_q;

  icr_cause_bank #(.NUM_EVT(NUM_EVT)) u_cause (
    .clk_i    (clk_i),
    .rst_n    (rst_sync_n),
    .evt_i    (evt_i),
    .sw_set_i (sw_set),
    .w1c_i    (w1c),
    .rd_clr_i (rd_clr),
    .mode_i   (mode_q),
    .cause_o  (cause_q)
  );

  icr_mask_mode #(.NUM_EVT(NUM_EVT)) u_mask (
    .clk_i     (clk_i),
    .rst_n     (rst_sync_n),
    .mset_en_i (mset_en),
    .mclr_en_i (mclr_en),
    .mode_en_i (mode_en),
    .wdata_i   (bus_wdata_i),
    .mask_o    (mask_q),
    .mode_o    (mode_q)
  );

  icr_read_port #(.NUM_EVT(NUM_EVT)) u_rd (
    .clk_i   (clk_i),
    .rst_n   (rst_sync_n),
    .rd_i    (bus_rd_i),
    .sel_i   (bus_addr_i),
    .cause_i (cause_q),
    .mask_i  (mask_q),
    .mode_i  (mode_q),
    .rdata_o (bus_rdata_o)
  );

  logic irq_d, irq_q;

  always_comb begin
    irq_d = |(cause_q & ~mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/icr_bank_chk.sv
module icr_bank_chk
  import icr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 32
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               wr_i,
  input logic               rd_i,
  input logic [SEL_W-1:0]   addr_i,
  input logic [NUM_EVT-1:0] wdata_i,
  input logic [NUM_EVT-1:0] rdata_i,
  input logic [NUM_EVT-1:0] cause,
  input logic [NUM_EVT-1:0] mask,
  input logic               irq
);

  // R2 R8
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|evt_i) |=> ((cause & $past(evt_i)) == $past(evt_i)));

  // R4
  mset_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && addr_i == SEL_MSET) |=> ((mask & $past(wdata_i)) == $past(wdata_i)));

  // R4
  mclr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && addr_i == SEL_MCLR) |=> ((mask & $past(wdata_i)) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_i && (addr_i == SEL_MSET || addr_i == SEL_MCLR)) |=> $stable(mask));

  // R6 R12
  cause_read_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && addr_i == SEL_CAUSE) |=> (rdata_i == $past(cause)));

  // R9
  no_side_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (evt_i == '0 && !wr_i && !(rd_i && addr_i == SEL_CAUSE)) |=> $stable(cause));

  // R10
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask == '1) |=> !irq);

endmodule

bind icr_bank icr_bank_chk #(.NUM_EVT(NUM_EVT)) chk_i (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .evt_i   (evt_i),
  .wr_i    (bus_wr_i),
  .rd_i    (bus_rd_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .rdata_i (bus_rdata_o),
  .cause   (cause_q),
  .mask    (mask_q),
  .irq     (irq_o)
);

// File: tb/icr_bank_tb.sv
module icr_bank_tb_top;

  localparam int unsigned W = 32;
  localparam logic [2:0] A_CAUSE = 3'd0;
  localparam logic [2:0] A_CSET  = 3'd1;
  localparam logic [2:0] A_MSET  = 3'd2;
  localparam logic [2:0] A_MCLR  = 3'd3;
  localparam logic [2:0] A_MODE  = 3'd4;
  localparam logic [2:0] A_MVIEW = 3'd5;
  localparam logic [2:0] A_MASKV = 3'd6;
  localparam logic [2:0] A_NONE  = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] evt;
  logic         wr, rd;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         irq;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_cause, m_mask, m_mode;
  logic [W-1:0] got;

  always #4 clk = ~clk;

  icr_bank #(.NUM_EVT(W)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .evt_i(evt), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      A_CAUSE: m_cause = m_cause & ~(d & ~m_mode);
      A_CSET:  m_cause = m_cause | d;
      A_MSET:  m_mask  = m_mask | d;
      A_MCLR:  m_mask  = m_mask & ~d;
      A_MODE:  m_mode  = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
    if (a == A_CAUSE) m_cause = m_cause & ~m_mode;
  endtask

  task automatic pulse(input logic [W-1:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
    m_cause = m_cause | v;
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(req, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(m_cause & ~m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    rst_n = 1'b0; evt = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    m_cause = '0; m_mask = '1; m_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {{(W-1){1'b0}}, irq}, '0);
    bus_read(A_CAUSE, got); chk("R1 cause", got, '0);
    bus_read(A_MASKV, got); chk("R1 mask", got, '1);
    bus_read(A_MODE,  got); chk("R1 mode", got, '0);
    // R12 write-only and unmapped selects read zero
    bus_read(A_CSET, got); chk("R12 cset", got, '0);
    bus_read(A_MSET, got); chk("R12 mset", got, '0);
    bus_read(A_MCLR, got); chk("R12 mclr", got, '0);
    bus_read(A_NONE, got); chk("R12 none", got, '0);

    // per-bit sweep with everything masked
    for (int b = 0; b < W; b++) begin
      v = '0; v[b] = 1'b1;
      pulse(v);
      chk_irq("R2 masked latch irq");
      bus_read(A_MVIEW, got); chk("R9 mview", got, '0);
      bus_read(A_CAUSE, got); chk("R2 latched", got, v);
      bus_read(A_CAUSE, got); chk("R7 no read clear", got, v);
      bus_write(A_CAUSE, v);
      bus_read(A_CAUSE, got); chk("R7 w1c", got, '0);
      bus_write(A_MODE, v);
      bus_read(A_MODE, got); chk("R5 mode rb", got, v);
      pulse(v);
      bus_read(A_CAUSE, got); chk("R6 read value", got, v);
      bus_read(A_CAUSE, got); chk("R6 read cleared", got, '0);
      bus_write(A_MODE, '0);
    end

    // R4 mask set/clear
    bus_write(A_MCLR, 32'h0000_FFFF);
    bus_read(A_MASKV, got); chk("R4 mclr", got, 32'hFFFF_0000);
    bus_write(A_MSET, 32'h0000_0F00);
    bus_read(A_MASKV, got); chk("R4 mset", got, 32'hFFFF_0F00);
    bus_write(A_MCLR, '0);
    bus_read(A_MASKV, got); chk("R4 zero no change", got, 32'hFFFF_0F00);

    // R3 cause-set and R10 one-stage irq
    @(negedge clk);
    wr = 1'b1; addr = A_CSET; wdata = 32'h0000_0081;
    @(negedge clk);
    wr = 1'b0; m_cause = m_cause | 32'h0000_0081;
    chk("R10 irq not yet", {{(W-1){1'b0}}, irq}, '0);
    @(negedge clk);
    chk("R10 irq next", {{(W-1){1'b0}}, irq}, 32'h1);
    bus_read(A_CAUSE, got); chk("R3 cset", got, 32'h0000_0081);
    bus_read(A_MVIEW, got); chk("R9 mview", got, 32'h0000_0081 & ~32'hFFFF_0F00);
    bus_read(A_CAUSE, got); chk("R9 no side effect", got, 32'h0000_0081);

    // R7 write back read value, later event survives
    bus_write(A_CSET, 32'h00F0_000F);
    bus_read(A_CAUSE, v);
    pulse(32'h4000_0000);
    bus_write(A_CAUSE, v);
    bus_read(A_CAUSE, got); chk("R7 write back", got, 32'h4000_0000);
    bus_write(A_CAUSE, '1);
    chk_irq("R10 irq after clear");

    // R6/R7 mixed modes
    bus_write(A_MODE, 32'h0000_FFFF);
    bus_write(A_CSET, 32'h00FF_00FF);
    bus_read(A_CAUSE, got); chk("R6 mixed value", got, 32'h00FF_00FF);
    bus_read(A_CAUSE, got); chk("R6 mixed keep w1c", got, 32'h00FF_0000);
    bus_write(A_CSET, 32'h1);
    bus_write(A_CAUSE, '1);
    bus_read(A_CAUSE, got); chk("R7 read-clear bit ignores write", got, 32'h1);

    // R8 set beats read-clear (bit 3, mode 1)
    bus_write(A_MODE, 32'h8);
    bus_write(A_CSET, 32'h8);
    @(negedge clk);
    rd = 1'b1; addr = A_CAUSE; evt = 32'h8;
    @(negedge clk);
    rd = 1'b0; evt = '0;
    chk("R8 read value", rdata, 32'h8);
    bus_read(A_CAUSE, got); chk("R8 survives read clear", got, 32'h8);
    // R8 set beats write-clear (bit 5, mode 0)
    bus_write(A_MODE, '0);
    bus_write(A_CSET, 32'h20);
    @(negedge clk);
    wr = 1'b1; addr = A_CAUSE; wdata = 32'h20; evt = 32'h20;
    @(negedge clk);
    wr = 1'b0; evt = '0;
    bus_read(A_CAUSE, got); chk("R8 survives write clear", got, 32'h20);
    bus_write(A_CAUSE, '1);
    m_cause = '0;

    // R11 handshake bit 27 alone unmasked
    bus_write(A_MCLR, '1);
    bus_write(A_MSET, 32'hF7FF_FFFF);
    bus_read(A_MASKV, got); chk("R11 mask pattern", got, 32'hF7FF_FFFF);
    pulse(32'h1);
    chk_irq("R11 other bit quiet");
    chk("R11 irq low", {{(W-1){1'b0}}, irq}, '0);
    pulse(32'h0800_0000);
    chk_irq("R11 bit27 raises");
    chk("R11 irq high", {{(W-1){1'b0}}, irq}, 32'h1);
    bus_read(A_MVIEW, got); chk("R11 mview", got, 32'h0800_0000);
    bus_write(A_CAUSE, 32'h0800_0000);
    chk_irq("R11 irq drops");
    chk("R11 irq low after", {{(W-1){1'b0}}, irq}, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule